// File: doc/BRIEF.md
# Read-Return Input Line Locator

This block watches the parallel serial data inputs of a time-slotted audio link and works out which input carried the answer to the one codec register read that is outstanding. Each input is shifted in on the falling edge of the link bit clock, which the block sees as a one-cycle strobe in its own clock domain. The frame sync sets the alignment. The block picks out three parts of each frame: the tag bits that say which slots are valid, the echoed address, and the returned data.

A read is armed by a request that carries the register address. When a frame on any input carries valid status, an echoed address that matches the armed one, and valid data, the block does four things. It drops the pending flag, latches the data word, raises a done flag and records a 2-bit code naming the input. No command is needed for this: the code is refreshed by every read that completes. All results are plain output levels, so observing them never changes state.

Top module: `sdin_return_locator`

## Requirements
- R1: The bit sampled on the first `bit_fall` strobe that sees `sync` high after seeing it low is tag bit 15. Each slot arrives MSB first. The 16-bit tag is followed by slot 1 (20 bits) and then slot 2 (20 bits).
- R2: A `req_valid` pulse while no read is pending latches `req_addr`, sets `pending` and clears `done`. These changes are visible one clock later.
- R3: A `req_valid` pulse while a read is pending is ignored. The address armed first stays in force.
- R4: A response is accepted only if tag bits 15, 14 and 13 are all 1. If any one of them is 0, the frame on that input is ignored.
- R5: Slot 1 bits 18:12 must equal the pending address. Slot 1 bit 19 and bits 11:0 are ignored.
- R6: On acceptance, `pending` clears, `done` sets and `rdata` takes slot 2 bits 19:4. These changes appear one clock after the strobe that samples slot 2 bit 0.
- R7: `line_code` is 2'b00 for input 0, 2'b01 for input 1 and 2'b10 for input 2.
- R8: When several inputs carry an acceptable response in the same frame, the lowest-numbered input is recorded and its data is latched.
- R9: Frames that arrive while no read is pending leave `line_code`, `rdata` and `done` unchanged, even when they carry valid matching responses.
- R10: Every accepted read refreshes `line_code` without any enabling command. The results hold until the next accepted read, and `done` holds until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_fall | input | 1 | One-cycle strobe at each bit-clock falling edge |
| sync | input | 1 | Frame sync level, sampled on `bit_fall` |
| sdin | input | 3 | Serial data inputs, bit i is input i |
| req_valid | input | 1 | Arms a register read |
| req_addr | input | 7 | Address of the read being armed |
| pending | output | 1 | A read is outstanding |
| done | output | 1 | The last armed read has completed |
| line_code | output | 2 | Input on which the last read returned |
| rdata | output | 16 | Data of the last completed read |

## Verification
The assertions assume that `bit_fall` is a single-cycle pulse and that no response is accepted unless `pending` was high before it. They also assume that `req_valid` is never issued in the same cycle as an accepting strobe. The bench keeps within these limits. It drives each bit with one strobe spaced four clocks apart, it raises requests only between frames, and it builds every frame from tag, address and data values that it chooses itself. It sweeps every combination of responding inputs, and it drops each tag bit and the address match one at a time.

// File: rtl/sdin_pkg.sv
package sdin_pkg;
   // Marks raised by the frame timer on the strobe that carries the last bit of a field
   typedef enum logic [1:0] {
      MARK_NONE = 2'd0,
      MARK_TAG  = 2'd1,
      MARK_ADDR = 2'd2,
      MARK_DATA = 2'd3
   } slot_mark_e;
endpackage

// File: rtl/sdin_frame_timer.sv
module sdin_frame_timer
   import sdin_pkg::*;
#(
   parameter int FRAME_BITS = 256,
   parameter int TAG_W      = 16,
   parameter int SLOT_W     = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_fall,
   input  logic       sync,
   output slot_mark_e mark
);
   localparam int CNT_W    = $clog2(FRAME_BITS);
   localparam int TAG_END  = TAG_W - 1;
   localparam int ADDR_END = TAG_W + SLOT_W - 1;
   localparam int DATA_END = TAG_W + 2*SLOT_W - 1;

   generate
      if (DATA_END >= FRAME_BITS) begin : g_bad_frame
         $error("frame too short for tag and two slots");
      end
   endgenerate

   logic             sync_q;
   logic             aligned;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] idx;
   logic             rise;

   assign rise = bit_fall && sync && !sync_q;
   assign idx  = rise ? '0 : cnt;

   always_comb begin
      mark = MARK_NONE;
      if (bit_fall && (aligned || rise)) begin
         if (idx == CNT_W'(TAG_END))       mark = MARK_TAG;
         else if (idx == CNT_W'(ADDR_END)) mark = MARK_ADDR;
         else if (idx == CNT_W'(DATA_END)) mark = MARK_DATA;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q  <= 1'b0;
         aligned <= 1'b0;
         cnt     <= '0;
      end else if (bit_fall) begin
         sync_q <= sync;
         cnt    <= idx + CNT_W'(1);
         if (rise) aligned <= 1'b1;
      end
   end
endmodule

// File: rtl/sdin_lane_capture.sv
module sdin_lane_capture
   import sdin_pkg::*;
#(
   parameter int TAG_W  = 16,
   parameter int SLOT_W = 20,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_fall,
   input  logic              sdin,
   input  slot_mark_e        mark,
   input  logic [ADDR_W-1:0] want_addr,
   output logic              hit,
   output logic [DATA_W-1:0] data
);
   generate
      if (ADDR_W > SLOT_W - 1 || DATA_W > SLOT_W || TAG_W < 3) begin : g_bad_fields
         $error("field widths do not fit the slot layout");
      end
   endgenerate

   logic [SLOT_W-2:0] shreg;
   logic [SLOT_W-1:0] word;
   logic              tag_ok;
   logic [ADDR_W-1:0] echo_addr;

   // word holds the current slot once the bit sampled now is appended
   assign word = {shreg, sdin};
   assign hit  = (mark == MARK_DATA) && tag_ok && (echo_addr == want_addr);
   assign data = word[SLOT_W-1 -: DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         tag_ok    <= 1'b0;
         echo_addr <= '0;
      end else if (bit_fall) begin
         shreg <= word[SLOT_W-2:0];
         if (mark == MARK_TAG)  tag_ok    <= &word[TAG_W-1 -: 3];
         if (mark == MARK_ADDR) echo_addr <= word[SLOT_W-2 -: ADDR_W];
      end
   end
endmodule

// File: rtl/sdin_pick_lowest.sv
module sdin_pick_lowest #(
   parameter int NUM_LINES = 3,
   parameter int DATA_W    = 16,
   localparam int CODE_W   = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] hits,
   input  logic [DATA_W-1:0]    lane_data [NUM_LINES],
   output logic                 any,
   output logic [CODE_W-1:0]    code,
   output logic [DATA_W-1:0]    data
);
   always_comb begin
      any  = 1'b0;
      code = '0;
      data = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (hits[i]) begin
            any  = 1'b1;
            code = CODE_W'(i);
            data = lane_data[i];
         end
      end
   end
endmodule

// File: rtl/sdin_return_locator.sv
module sdin_return_locator
   import sdin_pkg::*;
#(
   parameter int NUM_LINES  = 3,
   parameter int FRAME_BITS = 256,
   parameter int TAG_W      = 16,
   parameter int SLOT_W     = 20,
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 16,
   localparam int CODE_W    = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_fall,
   input  logic                 sync,
   input  logic [NUM_LINES-1:0] sdin,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   output logic                 pending,
   output logic                 done,
   output logic [CODE_W-1:0]    line_code,
   output logic [DATA_W-1:0]    rdata
);
   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("at least two input lines are required");
      end
   endgenerate

   slot_mark_e           mark;
   logic [ADDR_W-1:0]    want_addr;
   logic [NUM_LINES-1:0] hits;
   logic [DATA_W-1:0]    lane_data [NUM_LINES];
   logic                 hit_any;
   logic [CODE_W-1:0]    hit_code;
   logic [DATA_W-1:0]    hit_data;

   sdin_frame_timer #(
      .FRAME_BITS(FRAME_BITS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
   ) timer_i (
      .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .sync(sync), .mark(mark)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
      sdin_lane_capture #(
         .TAG_W(TAG_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
      ) lane_i (
         .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .sdin(sdin[g]),
         .mark(mark), .want_addr(want_addr), .hit(hits[g]), .data(lane_data[g])
      );
   end

   sdin_pick_lowest #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) pick_i (
      .hits(hits), .lane_data(lane_data), .any(hit_any), .code(hit_code), .data(hit_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         done      <= 1'b0;
         want_addr <= '0;
         line_code <= '0;
         rdata     <= '0;
      end else if (pending) begin
         if (hit_any) begin
            pending   <= 1'b0;
            done      <= 1'b1;
            line_code <= hit_code;
            rdata     <= hit_data;
         end
      end else if (req_valid) begin
         pending   <= 1'b1;
         done      <= 1'b0;
         want_addr <= req_addr;
      end
   end
endmodule

// File: rtl/sdin_return_locator_chk.sv
module sdin_return_locator_chk #(
   parameter int NUM_LINES = 3,
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 16,
   localparam int CODE_W   = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bit_fall,
   input logic                 req_valid,
   input logic                 pending,
   input logic                 done,
   input logic [CODE_W-1:0]    line_code,
   input logic [DATA_W-1:0]    rdata
);
   a_r2_request_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !pending) |=> (pending && !done));

   a_r3_rearm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && pending && !bit_fall) |=> pending);

   a_r6_done_ends_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($fell(pending) && $past(bit_fall)));

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && pending));

   a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      line_code < CODE_W'(NUM_LINES));

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |=> ($stable(line_code) && $stable(rdata)));
endmodule

bind sdin_return_locator sdin_return_locator_chk #(
   .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .req_valid(req_valid),
   .pending(pending), .done(done), .line_code(line_code), .rdata(rdata)
);

// File: tb/sdin_return_locator_tb.sv
module sdin_return_locator_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_fall = 1'b0;
   logic        sync = 1'b0;
   logic [2:0]  sdin = '0;
   logic        req_valid = 1'b0;
   logic [6:0]  req_addr = '0;
   logic        pending, done;
   logic [1:0]  line_code;
   logic [15:0] rdata;

   int vectors = 0;
   int miscompares = 0;

   logic [15:0] f_tag  [3];
   logic [6:0]  f_addr [3];
   logic [15:0] f_data [3];

   always #2 clk = ~clk;

   sdin_return_locator dut_i (
      .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .sync(sync), .sdin(sdin),
      .req_valid(req_valid), .req_addr(req_addr), .pending(pending), .done(done),
      .line_code(line_code), .rdata(rdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R1 layout: tag MSB first, slot1 {junk bit19, addr[18:12], 12'hABC}, slot2 {data, 4'h5}
   function automatic logic bit_of(input int ln, input int i);
      logic [19:0] s1, s2;
      s1 = {1'b1, f_addr[ln], 12'hABC};
      s2 = {f_data[ln], 4'h5};
      if (i < 16) return f_tag[ln][15 - i];
      if (i < 36) return s1[19 - (i - 16)];
      if (i < 56) return s2[19 - (i - 36)];
      return 1'b0;
   endfunction

   task automatic send_frame();
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         sync     = (i < 16);
         sdin     = {bit_of(2, i), bit_of(1, i), bit_of(0, i)};
         bit_fall = 1'b1;
         @(negedge clk);
         bit_fall = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic request(input logic [6:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_line(input int ln, input logic [15:0] t, input logic [6:0] a,
                           input logic [15:0] d);
      f_tag[ln] = t; f_addr[ln] = a; f_data[ln] = d;
   endtask

   task automatic silence();
      for (int l = 0; l < 3; l++) set_line(l, 16'h0, 7'h0, 16'h0);
   endtask

   initial begin
      #400000;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [1:0]  last_code;
      logic [15:0] last_data;
      silence();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("reset pending", int'(pending), 0);
      chk("reset done", int'(done), 0);
      chk("reset code", int'(line_code), 0);
      chk("reset rdata", int'(rdata), 0);
      send_frame();

      // R7 R8 R6 R10: sweep every set of responding lines
      for (int m = 0; m < 8; m++) begin
         logic [6:0] a;
         int low;
         a = 7'(8'h11 + m * 13);
         request(a);
         @(negedge clk);
         chk("R2 pending after request", int'(pending), 1);
         chk("R2 done cleared", int'(done), 0);
         silence();
         for (int l = 0; l < 3; l++)
            if (m[l]) set_line(l, 16'hE000 | 16'(m), a, 16'(16'h1234 + l * 16'h1111 + m));
         send_frame();
         low = m[0] ? 0 : (m[1] ? 1 : 2);
         if (m == 0) begin
            chk("R8 none pending", int'(pending), 1);
            chk("R8 none done", int'(done), 0);
            silence();
            set_line(1, 16'hE000, a, 16'hBEEF);
            send_frame();
            chk("R7 line1 code", int'(line_code), 1);
            chk("R6 line1 data", int'(rdata), 16'hBEEF);
         end else begin
            chk("R6 pending cleared", int'(pending), 0);
            chk("R6 done set", int'(done), 1);
            chk("R7 R8 code", int'(line_code), low);
            chk("R6 R8 data", int'(rdata), 16'h1234 + low * 16'h1111 + m);
         end
      end

      // R4: each required tag bit missing in turn
      for (int b = 13; b < 16; b++) begin
         request(7'h2A);
         silence();
         set_line(0, 16'hE000 & ~(16'h1 << b), 7'h2A, 16'h0F0F);
         send_frame();
         chk("R4 rejected pending", int'(pending), 1);
         chk("R4 rejected done", int'(done), 0);
         silence();
         set_line(2, 16'hFFFF, 7'h2A, 16'h7000 + 16'(b));
         send_frame();
         chk("R4 later accept code", int'(line_code), 2);
         chk("R4 later accept data", int'(rdata), 16'h7000 + b);
      end

      // R5: wrong echoed address ignored
      request(7'h55);
      silence();
      set_line(0, 16'hE000, 7'h54, 16'hAAAA);
      send_frame();
      chk("R5 mismatch pending", int'(pending), 1);
      set_line(0, 16'hE000, 7'h55, 16'hAAAB);
      send_frame();
      chk("R5 match data", int'(rdata), 16'hAAAB);
      chk("R5 match code", int'(line_code), 0);

      // R9: frames with no pending read leave results alone
      last_code = line_code;
      last_data = rdata;
      silence();
      set_line(2, 16'hE000, 7'h55, 16'h9999);
      send_frame();
      chk("R9 code held", int'(line_code), int'(last_code));
      chk("R9 data held", int'(rdata), int'(last_data));
      chk("R9 R10 done held", int'(done), 1);

      // R3: second request while pending is ignored
      request(7'h10);
      request(7'h20);
      silence();
      set_line(1, 16'hE000, 7'h20, 16'h2020);
      send_frame();
      chk("R3 second addr ignored", int'(pending), 1);
      set_line(1, 16'hE000, 7'h10, 16'h1010);
      send_frame();
      chk("R3 first addr accepted", int'(rdata), 16'h1010);
      chk("R3 R10 code refreshed", int'(line_code), 1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule